// File: doc/BRIEF.md
# Dual Masked Calendar Alarm Comparator

This block keeps two independent alarm register sets beside a BCD real-time clock. Each set holds a target value for seconds, minutes, hours, date, month and day of week. Every field carries its own enable bit. On each seconds strobe, which the clock raises after it has advanced, every alarm compares its enabled fields with the live clock fields. A full match sets a sticky flag for that alarm.

Because each field is enabled on its own, one comparator gives several alarm kinds. Month, date, hour, minute and second together fire once a year. Date, hour, minute and second fire once a month. Hour, minute and second fire once a day. Seconds alone fire once a minute. Alarm hours are held in 24-hour form only. A live hour in 12-hour form is converted to 24-hour form before the comparison.

Top module: `calendar_alarm_compare`

## Requirements
- R1: After reset both alarm flags read 0 and every field enable of both alarms is clear.
- R2: A write with `wrEn` high loads `wrData` into the field of alarm `wrAlarm` selected by `wrField`. The field codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month and 5 day of week. In each field byte, bit 7 is the enable and bits 6:0 hold the BCD value. Field codes 6 and 7 change nothing.
- R3: Comparison happens only on a cycle with `secTick` high. A matching alarm shows its flag at the clock edge that samples the tick, and a matching time without a tick sets nothing.
- R4: Only enabled fields take part in the match, so a disabled field that differs from the clock does not block a match. One enabled field that differs does block it.
- R5: An alarm with no enable bit set never sets its flag.
- R6: A flag stays set across later ticks, matching or not, until a write with `clrEn` high has bit i of `clrMask` set, which clears flag i.
- R7: When a clear and a match for the same alarm fall in the same cycle, the flag ends up set.
- R8: `rtcHour` bit 7 high means 24-hour form, with bits 5:0 as BCD 00-23. Bit 7 low means 12-hour form, with bit 5 as PM and bits 4:0 as BCD 1-12. The hour 12 AM compares as 00, 12 PM compares as 12, and any other PM hour compares as that hour plus 12.
- R9: The two alarms are independent: a match or clear of one leaves the other's flag unchanged.
- R10: A write in the same cycle as a tick does not affect that tick's comparison, which uses the field contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-cycle strobe raised after the clock has advanced |
| rtcSec | input | 8 | Live seconds, BCD |
| rtcMin | input | 8 | Live minutes, BCD |
| rtcHour | input | 8 | Live hour with mode bit (see R8) |
| rtcDate | input | 8 | Live date, BCD |
| rtcMonth | input | 8 | Live month, BCD |
| rtcDow | input | 8 | Live day of week, 0-6 |
| wrEn | input | 1 | Alarm field write strobe |
| wrAlarm | input | 1 | Alarm index for the write |
| wrField | input | 3 | Field code for the write |
| wrData | input | 8 | Enable bit and BCD value |
| clrEn | input | 1 | Flag clear strobe |
| clrMask | input | 2 | Flags to clear |
| alarmFlag | output | 2 | Sticky match flags, bit i for alarm i |

## Verification
The bench targets the 12-hour corners: 12 AM, 12 PM and a PM hour past noon. A converter that treated 12 AM as 12, or left PM hours unshifted, would miss these matches or match the wrong hour. It checks that a disabled field holding a different value still lets the alarm fire, and that an all-disabled alarm stays silent. A design that let either case through would fire every second or block a valid alarm. It also lands a clear on a matching tick and a write on a tick. A wrong priority in either case would drop a real match or compare against a value that had not yet been written. Writes to the unused field codes are checked so that they do not alias onto real fields.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ALARM_COUNT = 2;
  localparam int ALARM_IDX_W = (ALARM_COUNT > 1) ? $clog2(ALARM_COUNT) : 1;
  localparam int FIELD_COUNT = 6;
  localparam int FIELD_W     = 8;
  localparam int FIELD_SEL_W = 3;
  localparam int EN_BIT      = FIELD_W - 1;

  typedef enum logic [FIELD_SEL_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5
  } fieldSel_e;

  typedef struct packed {
    logic                   cmp;
    logic [ALARM_COUNT-1:0] clr;
    logic [ALARM_COUNT-1:0] wr;
  } almStrobe_t;

  // significant value bits of each field
  function automatic logic [EN_BIT-1:0] fieldMask(input int f);
    case (f)
      FLD_SEC, FLD_MIN:    return 7'h7F;
      FLD_HOUR, FLD_DATE:  return 7'h3F;
      FLD_MONTH:           return 7'h1F;
      default:             return 7'h07;
    endcase
  endfunction

  // live hour byte -> BCD hour in 24-hour form
  function automatic logic [5:0] hourTo24(input logic [7:0] h);
    logic [4:0] bin;
    logic [4:0] hr;
    logic [1:0] tens;
    logic [3:0] ones;
    if (h[7]) return h[5:0];
    bin = 5'(h[4]) * 5'd10 + 5'(h[3:0]);
    if (bin == 5'd12) hr = h[5] ? 5'd12 : 5'd0;
    else              hr = h[5] ? bin + 5'd12 : bin;
    tens = (hr >= 5'd20) ? 2'd2 : (hr >= 5'd10) ? 2'd1 : 2'd0;
    ones = 4'(hr - 5'(tens) * 5'd10);
    return {tens, ones};
  endfunction
endpackage

// File: rtl/alm_ctrl.sv
module alm_ctrl
  import alm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   secTick,
  input  logic                   wrEn,
  input  logic [ALARM_IDX_W-1:0] wrAlarm,
  input  logic [FIELD_SEL_W-1:0] wrField,
  input  logic                   clrEn,
  input  logic [ALARM_COUNT-1:0] clrMask,
  output almStrobe_t             strobe
);
  logic fieldOk;

  assign fieldOk = (wrField < FIELD_SEL_W'(FIELD_COUNT));

  always_comb begin
    strobe.cmp = secTick;
    strobe.clr = clrEn ? clrMask : '0;
    for (int a = 0; a < ALARM_COUNT; a++)
      strobe.wr[a] = wrEn && fieldOk && (wrAlarm == ALARM_IDX_W'(a));
  end

  // R2: at most one alarm set takes a write
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wr));
  // R2: unused field codes reach no register
  a_r2_bad_field: assert property (@(posedge clk) disable iff (!rstN)
    (wrField >= FIELD_SEL_W'(FIELD_COUNT)) |-> (strobe.wr == '0));
endmodule

// File: rtl/alm_datapath.sv
module alm_datapath
  import alm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  almStrobe_t                          strobe,
  input  logic [FIELD_SEL_W-1:0]              wrField,
  input  logic [FIELD_W-1:0]                  wrData,
  input  logic [FIELD_COUNT-1:0][FIELD_W-1:0] live,
  output logic [ALARM_COUNT-1:0]              flag
);
  logic [FIELD_COUNT-1:0][FIELD_W-1:0] liveNorm;
  logic [ALARM_COUNT-1:0]              match;
  logic [ALARM_COUNT-1:0]              anyEn;

  always_comb begin
    liveNorm = live;
    liveNorm[FLD_HOUR] = {2'b00, hourTo24(live[FLD_HOUR])};
  end

  for (genvar a = 0; a < ALARM_COUNT; a++) begin : g_alarm
    logic [FIELD_COUNT-1:0][FIELD_W-1:0] fieldReg;

    for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_field
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          fieldReg[f] <= '0;
        else if (strobe.wr[a] && wrField == FIELD_SEL_W'(f))
          fieldReg[f] <= wrData;
      end
    end

    always_comb begin
      match[a] = 1'b1;
      anyEn[a] = 1'b0;
      for (int f = 0; f < FIELD_COUNT; f++) begin
        if (fieldReg[f][EN_BIT]) begin
          anyEn[a] = 1'b1;
          if ((fieldReg[f][EN_BIT-1:0] & fieldMask(f)) !=
              (liveNorm[f][EN_BIT-1:0] & fieldMask(f)))
            match[a] = 1'b0;
        end
      end
      match[a] = match[a] & anyEn[a];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flag[a] <= 1'b0;
      else       flag[a] <= (flag[a] & ~strobe.clr[a]) | (strobe.cmp & match[a]);
    end

    // R6: a set flag survives any cycle without a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (flag[a] && !strobe.clr[a]) |=> flag[a]);
    // R6: a clear without a compare empties the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clr[a] && !strobe.cmp) |=> !flag[a]);
    // R3: a flag only rises after a compare strobe
    a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flag[a]) |-> $past(strobe.cmp));
    // R5: an alarm with nothing enabled stays quiet
    a_r5_no_enable: assert property (@(posedge clk) disable iff (!rstN)
      (!anyEn[a] && !flag[a]) |=> !flag[a]);
  end
endmodule

// File: rtl/calendar_alarm_compare.sv
module calendar_alarm_compare
  import alm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   secTick,
  input  logic [FIELD_W-1:0]     rtcSec,
  input  logic [FIELD_W-1:0]     rtcMin,
  input  logic [FIELD_W-1:0]     rtcHour,
  input  logic [FIELD_W-1:0]     rtcDate,
  input  logic [FIELD_W-1:0]     rtcMonth,
  input  logic [FIELD_W-1:0]     rtcDow,
  input  logic                   wrEn,
  input  logic [ALARM_IDX_W-1:0] wrAlarm,
  input  logic [FIELD_SEL_W-1:0] wrField,
  input  logic [FIELD_W-1:0]     wrData,
  input  logic                   clrEn,
  input  logic [ALARM_COUNT-1:0] clrMask,
  output logic [ALARM_COUNT-1:0] alarmFlag
);
  almStrobe_t                          strobe;
  logic [FIELD_COUNT-1:0][FIELD_W-1:0] live;

  always_comb begin
    live[FLD_SEC]   = rtcSec;
    live[FLD_MIN]   = rtcMin;
    live[FLD_HOUR]  = rtcHour;
    live[FLD_DATE]  = rtcDate;
    live[FLD_MONTH] = rtcMonth;
    live[FLD_DOW]   = rtcDow;
  end

  alm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrAlarm(wrAlarm), .wrField(wrField), .clrEn(clrEn),
    .clrMask(clrMask), .strobe(strobe)
  );

  alm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrField(wrField),
    .wrData(wrData), .live(live), .flag(alarmFlag)
  );
endmodule

// File: tb/calendar_alarm_compare_test.sv
module calendar_alarm_compare_test;
  logic clk = 0, rstN = 0, secTick = 0;
  logic [7:0] rtcSec = 0, rtcMin = 0, rtcHour = 8'h80, rtcDate = 8'h01, rtcMonth = 8'h01, rtcDow = 0;
  logic wrEn = 0, wrAlarm = 0, clrEn = 0;
  logic [2:0] wrField = 0;
  logic [7:0] wrData = 0;
  logic [1:0] clrMask = 0, alarmFlag;
  int checks = 0, errors = 0;
  bit done = 0;

  calendar_alarm_compare uut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: alarmFlag=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [2:0] f, input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAlarm = a; wrField = f; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk); clrEn = 1; clrMask = m;
    @(negedge clk); clrEn = 0; clrMask = 0;
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1;
    @(negedge clk); secTick = 0;
  endtask

  task automatic setLive(input logic [7:0] s, mi, h, d, mo, w);
    rtcSec = s; rtcMin = mi; rtcHour = h; rtcDate = d; rtcMonth = mo; rtcDow = w;
  endtask

  task automatic wipe();
    for (int a = 0; a < 2; a++)
      for (int f = 0; f < 6; f++) wr(a[0], f[2:0], 8'h00);
    clr(2'b11);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset flags", alarmFlag, 2'b00);
    setLive(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00);
    tick();
    check("R1 enables clear after reset", alarmFlag, 2'b00);
  endtask

  task automatic t_noEnable();
    wr(0, 3'd0, 8'h45); wr(0, 3'd1, 8'h10);
    setLive(8'h45, 8'h10, 8'h80, 8'h01, 8'h01, 8'h00);
    tick();
    check("R5 no enables never fires", alarmFlag, 2'b00);
  endtask

  task automatic t_yearly();
    wipe();
    wr(0, 3'd0, 8'h80 | 8'h30); wr(0, 3'd1, 8'h80 | 8'h15);
    wr(0, 3'd2, 8'h80 | 8'h21); wr(0, 3'd3, 8'h80 | 8'h28);
    wr(0, 3'd4, 8'h80 | 8'h11);
    setLive(8'h30, 8'h15, 8'h80 | 8'h21, 8'h28, 8'h11, 8'h03);
    repeat (3) @(negedge clk);
    check("R3 no tick no flag", alarmFlag, 2'b00);
    tick();
    check("R3 R2 R9 yearly match sets only alarm0", alarmFlag, 2'b01);
    rtcMonth = 8'h12;
    tick();
    check("R6 sticky across mismatching tick", alarmFlag, 2'b01);
    clr(2'b10);
    check("R9 clearing alarm1 leaves alarm0", alarmFlag, 2'b01);
    clr(2'b01);
    check("R6 clear drops flag", alarmFlag, 2'b00);
    tick();
    check("R2 month field compared", alarmFlag, 2'b00);
  endtask

  task automatic t_masking();
    wipe();
    wr(1, 3'd1, 8'h80 | 8'h42); wr(1, 3'd5, 8'h05);
    setLive(8'h07, 8'h42, 8'h80 | 8'h09, 8'h03, 8'h02, 8'h02);
    tick();
    check("R4 disabled dow ignored", alarmFlag, 2'b10);
    clr(2'b10);
    rtcMin = 8'h43;
    tick();
    check("R4 enabled minute mismatch blocks", alarmFlag, 2'b00);
  endtask

  task automatic t_hour12();
    wipe();
    wr(1, 3'd2, 8'h80 | 8'h15);
    setLive(8'h00, 8'h00, 8'h23, 8'h01, 8'h01, 8'h00);
    tick();
    check("R8 3 PM compares as 15", alarmFlag, 2'b10);
    clr(2'b10);
    rtcHour = 8'h03;
    tick();
    check("R8 3 AM not 15", alarmFlag, 2'b00);
    wr(1, 3'd2, 8'h80 | 8'h00);
    rtcHour = 8'h12;
    tick();
    check("R8 12 AM compares as 00", alarmFlag, 2'b10);
    clr(2'b10);
    rtcHour = 8'h32;
    tick();
    check("R8 12 PM not 00", alarmFlag, 2'b00);
    wr(1, 3'd2, 8'h80 | 8'h12);
    tick();
    check("R8 12 PM compares as 12", alarmFlag, 2'b10);
    clr(2'b10);
    rtcHour = 8'h80 | 8'h12;
    tick();
    check("R8 24-hour form direct", alarmFlag, 2'b10);
    clr(2'b10);
  endtask

  task automatic t_setWins();
    wipe();
    wr(0, 3'd0, 8'h80 | 8'h20);
    rtcSec = 8'h20;
    @(negedge clk); secTick = 1; clrEn = 1; clrMask = 2'b01;
    @(negedge clk); secTick = 0; clrEn = 0; clrMask = 0;
    check("R7 set wins over clear", alarmFlag, 2'b01);
    clr(2'b01);
  endtask

  task automatic t_badField();
    wipe();
    wr(1, 3'd0, 8'h80 | 8'h10);
    wr(1, 3'd6, 8'h80 | 8'h20);
    wr(1, 3'd7, 8'h80 | 8'h20);
    rtcSec = 8'h10; rtcMin = 8'h33;
    tick();
    check("R2 field codes 6 and 7 ignored", alarmFlag, 2'b10);
    clr(2'b10);
  endtask

  task automatic t_writeOnTick();
    wipe();
    wr(1, 3'd0, 8'h80 | 8'h10);
    rtcSec = 8'h11;
    @(negedge clk); secTick = 1; wrEn = 1; wrAlarm = 1; wrField = 3'd0; wrData = 8'h80 | 8'h11;
    @(negedge clk); secTick = 0; wrEn = 0;
    check("R10 tick uses pre-write value", alarmFlag, 2'b00);
    tick();
    check("R10 written value used next tick", alarmFlag, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_noEnable();
    t_yearly();
    t_masking();
    t_hour12();
    t_setWins();
    t_badField();
    t_writeOnTick();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule